// File: doc/BRIEF.md
# Sequential Cube Operation Cell Array

This block is a linear array of identical cells that produces, one after another, the result cubes of a sequential cube calculus operation. Two operand cubes are supplied in positional notation: each cell sees two value bits of operand A and two of operand B and returns two result bits. A variable with more than two values spans several adjacent cells, and its last cell is marked in an edge mask. Cells marked in an unused mask drop out of the array and pass every chain straight through.

All Boolean behaviour is programmed through 4-bit truth tables. One table gives the per-value partial relation, and a type bit chooses whether a variable matches when all of its partial relation bits are set or when any of them is. Three more tables give the output function for cells before, at, and after the current active variable. A start input feeds a chain that runs from the leftmost cell. Each strobe of the step input advances the array by one matching variable. The three-state machine in each cell records where that cell stands relative to the active variable. The `ready` output shows that another matching variable is waiting. The `term` output shows that the chain has reached the right end. The `empty` output flags a result cube in which some variable has no value left.

Top module: `cca_array`

## Requirements
- R1: While `rst_n` is low every cell is in the before state, so with `start` high and no step taken each used cell's result bits come from the before table.
- R2: A truth table `t[3:0]` applied to bits a and b gives `t[{a,b}]`; bit pair k of an operand (cell k, k = 0 at the left) is `a0 = opa[2k]`, `a1 = opa[2k+1]`, and the result uses the same positions.
- R3: A cell in the before state uses `bef_tt`, in the active state `act_tt`, and in the after state `aft_tt`, on both of its value pairs.
- R4: Each step with `start` high makes the leftmost not-yet-used matching variable active; every cell to its left is then in the after state and every cell to its right stays before.
- R5: A variable matches when the AND (`rel_and`=1) or the OR (`rel_and`=0) over all `rel_tt` partial bits of all its cells is 1, for variables spanning one or several cells, so all of a variable's cells share one match result.
- R6: A cell with its `unused_mask` bit set outputs 00, never changes state, and is transparent to every chain, including a variable that spans it.
- R7: `ready` is 1 exactly when a matching variable still in the before state receives the start chain; it is never 1 together with `term`.
- R8: `term` is 1 when the start chain leaves the last cell: when no variable matches, when the last matching variable is active, or when all of them have been used.
- R9: `empty` is 1 when some used variable's result bits are all zero in the current result.
- R10: Cell states change only on a clock edge with `step` high; a step while `start` is low leaves every cell before.
- R11: An active cell goes to after on the next step, and a cell in the after state stays there until reset, even when further steps arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the before state |
| step | input | 1 | Advance strobe, qualifies the state clock edge |
| start | input | 1 | Chain input into the leftmost cell |
| opa | input | 2*NCELL | Operand cube A, two bits per cell |
| opb | input | 2*NCELL | Operand cube B, two bits per cell |
| rel_tt | input | 4 | Partial relation truth table |
| rel_and | input | 1 | Relation type: 1 AND, 0 OR |
| bef_tt | input | 4 | Output table for before cells |
| act_tt | input | 4 | Output table for active cells |
| aft_tt | input | 4 | Output table for after cells |
| unused_mask | input | NCELL | 1 marks a cell left out of the operation |
| edge_mask | input | NCELL | 1 marks the last cell of a variable |
| result | output | 2*NCELL | Current result cube |
| term | output | 1 | Start chain leaving the last cell |
| ready | output | 1 | Another matching variable is waiting |
| empty | output | 1 | Some variable of the result has no value |

## Verification
The bench builds the array with NCELL = 6. Six cells are few enough to cover every state sequence, and enough to hold three four-valued variables, mixed binary and multi-valued layouts, and unused cells placed inside a variable and at the right end. A variable-level model in the bench recomputes each step's expected cube and flags from the masks and tables. The model covers the cases with no match and with a match in the rightmost variable, steps beyond the last match, and a start held low.

// File: rtl/cca_pkg.sv
package cca_pkg;

  typedef enum logic [1:0] {
    ST_BEF = 2'b00,
    ST_ACT = 2'b01,
    ST_AFT = 2'b10
  } cca_st_e;

  // Four-entry truth table lookup, index {a,b}
  function automatic logic tt_apply(input logic [3:0] tt, input logic a, input logic b);
    return tt[{a, b}];
  endfunction

endpackage

// File: rtl/cca_ident.sv
// Match detection: forward carry across a variable, backward confirm
module cca_ident
  import cca_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic [3:0] rel_tt,
  input  logic       rel_and,
  input  logic       unused,
  input  logic       is_edge,
  input  logic       first_in,
  input  logic       carry_in,
  input  logic       conf_in,
  output logic       first_out,
  output logic       carry_out,
  output logic       conf_out,
  output logic       var_hit
);

  logic p0, p1, part, seed, comb;

  always_comb begin
    p0        = tt_apply(rel_tt, a[0], b[0]);
    p1        = tt_apply(rel_tt, a[1], b[1]);
    part      = rel_and ? (p0 & p1) : (p0 | p1);
    seed      = first_in ? rel_and : carry_in;
    comb      = rel_and ? (seed & part) : (seed | part);
    carry_out = unused ? carry_in : comb;
    first_out = unused ? first_in : is_edge;
    var_hit   = is_edge ? comb : conf_in;
    conf_out  = unused ? conf_in : var_hit;
  end

endmodule

// File: rtl/cca_state.sv
// Position state machine and start-chain stage of one cell
module cca_state
  import cca_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    unused,
  input  logic    is_edge,
  input  logic    var_hit,
  input  logic    nxt_in,
  output cca_st_e st,
  output logic    nxt_out,
  output logic    subready
);

  cca_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!unused) begin
      unique case (st_q)
        ST_BEF:  if (nxt_in) st_d = var_hit ? ST_ACT : ST_AFT;
        ST_ACT:  st_d = ST_AFT;
        ST_AFT:  st_d = ST_AFT;
        default: st_d = ST_BEF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_BEF;
    end else if (step) begin
      st_q <= st_d;
    end
  end

  always_comb begin
    st       = st_q;
    nxt_out  = unused ? nxt_in
             : ((st_q == ST_ACT) | (nxt_in & ((st_q == ST_AFT) | ~var_hit | ~is_edge)));
    subready = ~unused & (st_q == ST_BEF) & nxt_in & var_hit;
  end

endmodule

// File: rtl/cca_oper.sv
// Output literal generation and per-variable emptiness chain
module cca_oper
  import cca_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  cca_st_e    st,
  input  logic [3:0] bef_tt,
  input  logic [3:0] act_tt,
  input  logic [3:0] aft_tt,
  input  logic       unused,
  input  logic       is_edge,
  input  logic       first_in,
  input  logic       any_in,
  input  logic       emp_in,
  output logic [1:0] c,
  output logic       any_out,
  output logic       emp_out
);

  logic [3:0] tsel;
  logic       any_loc;

  always_comb begin
    unique case (st)
      ST_BEF:  tsel = bef_tt;
      ST_ACT:  tsel = act_tt;
      ST_AFT:  tsel = aft_tt;
      default: tsel = 4'b0000;
    endcase
    c[0]    = ~unused & tt_apply(tsel, a[0], b[0]);
    c[1]    = ~unused & tt_apply(tsel, a[1], b[1]);
    any_loc = (~first_in & any_in) | c[0] | c[1];
    any_out = unused ? any_in : any_loc;
    emp_out = unused ? emp_in : (emp_in | (is_edge & ~any_loc));
  end

endmodule

// File: rtl/cca_array.sv
module cca_array
  import cca_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 start,
  input  logic [2*NCELL-1:0]   opa,
  input  logic [2*NCELL-1:0]   opb,
  input  logic [3:0]           rel_tt,
  input  logic                 rel_and,
  input  logic [3:0]           bef_tt,
  input  logic [3:0]           act_tt,
  input  logic [3:0]           aft_tt,
  input  logic [NCELL-1:0]     unused_mask,
  input  logic [NCELL-1:0]     edge_mask,
  output logic [2*NCELL-1:0]   result,
  output logic                 term,
  output logic                 ready,
  output logic                 empty
);

  localparam int W = 2 * NCELL;

  logic [NCELL:0]   first_c, carry_c, conf_c, nxt_c, any_c, emp_c;
  logic [NCELL-1:0] var_v, subrdy_v, act_v, aft_v;
  logic             chain_ends_unused;

  assign first_c[0]     = 1'b1;
  assign carry_c[0]     = 1'b0;
  assign conf_c[NCELL]  = 1'b0;
  assign nxt_c[0]       = start;
  assign any_c[0]       = 1'b0;
  assign emp_c[0]       = 1'b0;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cca_st_e st_i;

    cca_ident u_ident (
      .a         (opa[2*i +: 2]),
      .b         (opb[2*i +: 2]),
      .rel_tt    (rel_tt),
      .rel_and   (rel_and),
      .unused    (unused_mask[i]),
      .is_edge   (edge_mask[i]),
      .first_in  (first_c[i]),
      .carry_in  (carry_c[i]),
      .conf_in   (conf_c[i+1]),
      .first_out (first_c[i+1]),
      .carry_out (carry_c[i+1]),
      .conf_out  (conf_c[i]),
      .var_hit   (var_v[i])
    );

    cca_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .unused   (unused_mask[i]),
      .is_edge  (edge_mask[i]),
      .var_hit  (var_v[i]),
      .nxt_in   (nxt_c[i]),
      .st       (st_i),
      .nxt_out  (nxt_c[i+1]),
      .subready (subrdy_v[i])
    );

    cca_oper u_oper (
      .a        (opa[2*i +: 2]),
      .b        (opb[2*i +: 2]),
      .st       (st_i),
      .bef_tt   (bef_tt),
      .act_tt   (act_tt),
      .aft_tt   (aft_tt),
      .unused   (unused_mask[i]),
      .is_edge  (edge_mask[i]),
      .first_in (first_c[i]),
      .any_in   (any_c[i]),
      .emp_in   (emp_c[i]),
      .c        (result[2*i +: 2]),
      .any_out  (any_c[i+1]),
      .emp_out  (emp_c[i+1])
    );

    assign act_v[i] = (st_i == ST_ACT);
    assign aft_v[i] = (st_i == ST_AFT);
  end

  assign ready = |subrdy_v;
  assign term  = nxt_c[NCELL];
  assign empty = emp_c[NCELL];

  assign chain_ends_unused = ^{first_c[NCELL], carry_c[NCELL], conf_c[0], any_c[NCELL], W[0]};

endmodule

// File: rtl/cca_array_chk.sv
module cca_array_chk #(
  parameter int NCELL = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step,
  input logic               ready,
  input logic               term,
  input logic [NCELL-1:0]   unused_mask,
  input logic [NCELL-1:0]   act_v,
  input logic [NCELL-1:0]   aft_v,
  input logic [2*NCELL-1:0] result
);

  AST_AFT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((aft_v & $past(aft_v)) == $past(aft_v))); // R11

  AST_ACT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((aft_v & $past(act_v)) == $past(act_v))); // R11

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(act_v) && $stable(aft_v))); // R10

  AST_READY_NOT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !term); // R7

  for (genvar i = 0; i < NCELL; i++) begin : g_unused
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unused_mask[i] |-> (result[2*i +: 2] == 2'b00)); // R6
  end

endmodule

bind cca_array cca_array_chk #(.NCELL(NCELL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step        (step),
  .ready       (ready),
  .term        (term),
  .unused_mask (unused_mask),
  .act_v       (act_v),
  .aft_v       (aft_v),
  .result      (result)
);

// File: tb/cca_array_tb.sv
`timescale 1ns/1ps
module cca_array_tb;

  localparam int N = 6;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n, step, start, rel_and;
  logic [W-1:0] opa, opb;
  logic [3:0]   rel_tt, bef_tt, act_tt, aft_tt;
  logic [N-1:0] unused_mask, edge_mask;
  logic [W-1:0] result;
  logic         term, ready, empty;

  always #2.5 clk = ~clk;

  cca_array #(.NCELL(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .start(start),
    .opa(opa), .opb(opb), .rel_tt(rel_tt), .rel_and(rel_and),
    .bef_tt(bef_tt), .act_tt(act_tt), .aft_tt(aft_tt),
    .unused_mask(unused_mask), .edge_mask(edge_mask),
    .result(result), .term(term), .ready(ready), .empty(empty)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         rdy;
    logic         trm;
    logic         emp;
    string        tag;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  event sample_ev;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the expected item and compares with the outputs
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL [R4] scoreboard empty actual=1 expected=0");
      end else begin
        e = expq.pop_front();
        chk(e.tag, "R2 R3 result", result, e.res);
        chk(e.tag, "R7 ready", {{(W-1){1'b0}}, ready}, {{(W-1){1'b0}}, e.rdy});
        chk(e.tag, "R8 term",  {{(W-1){1'b0}}, term},  {{(W-1){1'b0}}, e.trm});
        chk(e.tag, "R9 empty", {{(W-1){1'b0}}, empty}, {{(W-1){1'b0}}, e.emp});
      end
    end
  end

  function automatic logic ttv(logic [3:0] t, logic a, logic b);
    return t[{a, b}];
  endfunction

  // Driver: model the operation at variable level, push, then stimulate
  task automatic run_op(string nm, logic [W-1:0] a, logic [W-1:0] b,
                        logic [3:0] rt, logic ra, logic [3:0] bt, logic [3:0] at,
                        logic [3:0] ft, logic [N-1:0] um, logic [N-1:0] em,
                        logic st_on, int extra);
    int   vid[N];
    logic vm[N];
    int   mlist[$];
    int   nv, k;
    logic acc;
    nv = 0; acc = ra;
    for (int c = 0; c < N; c++) begin
      logic p0, p1, pc;
      vid[c] = -1;
      if (!um[c]) begin
        p0  = ttv(rt, a[2*c], b[2*c]);
        p1  = ttv(rt, a[2*c+1], b[2*c+1]);
        pc  = ra ? (p0 & p1) : (p0 | p1);
        acc = ra ? (acc & pc) : (acc | pc);
        vid[c] = nv;
        if (em[c]) begin vm[nv] = acc; nv++; acc = ra; end
      end
    end
    for (int v = 0; v < nv; v++) if (vm[v]) mlist.push_back(v);
    k = mlist.size();

    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    opa = a; opb = b; rel_tt = rt; rel_and = ra;
    bef_tt = bt; act_tt = at; aft_tt = ft;
    unused_mask = um; edge_mask = em; start = st_on;
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s <= k + 1 + extra; s++) begin
      exp_t e;
      logic anyv[N];
      int   actv;
      for (int v = 0; v < N; v++) anyv[v] = 1'b0;
      actv = (st_on && s >= 1 && s <= k) ? mlist[s-1] : -1;
      e.res = '0;
      for (int c = 0; c < N; c++) begin
        int         stc;
        logic [3:0] t;
        if (vid[c] >= 0) begin
          if (!st_on || s == 0) stc = 0;
          else if (s > k)       stc = 2;
          else if (vid[c] < actv) stc = 2;
          else if (vid[c] == actv) stc = 1;
          else stc = 0;
          t = (stc == 0) ? bt : (stc == 1) ? at : ft;
          e.res[2*c]   = ttv(t, a[2*c], b[2*c]);
          e.res[2*c+1] = ttv(t, a[2*c+1], b[2*c+1]);
          if (e.res[2*c] | e.res[2*c+1]) anyv[vid[c]] = 1'b1;
        end
      end
      e.emp = 1'b0;
      for (int v = 0; v < nv; v++) if (!anyv[v]) e.emp = 1'b1;
      e.rdy = st_on && ((s == 0) ? (k > 0) : (s < k));
      e.trm = st_on && ((s == 0) ? (k == 0) : (s >= k));
      e.tag = (s == 0) ? {nm, " R1"} : (s > k) ? {nm, " R11"} : nm;
      expq.push_back(e);
      if (s > 0) begin
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
      end
      #1;
      -> sample_ev;
      #1;
    end
  endtask

  initial begin
    rst_n = 1'b0; step = 1'b0; start = 1'b0; rel_and = 1'b0;
    opa = '0; opb = '0; rel_tt = '0; bef_tt = '0; act_tt = '0; aft_tt = '0;
    unused_mask = '0; edge_mask = '1;
    repeat (2) @(negedge clk);

    // binary variables, OR relation, intersection test
    run_op("R4 binary", 12'b01_11_10_01_11_10, 12'b11_01_01_10_10_11,
           4'b1000, 1'b0, 4'b1100, 4'b0100, 4'b1000, 6'b000000, 6'b111111, 1'b1, 1);
    // three four-valued variables, AND relation with implication table
    run_op("R5 multi", 12'b11_01_10_00_01_11, 12'b11_11_10_01_01_11,
           4'b1011, 1'b1, 4'b0110, 4'b1110, 4'b0010, 6'b000000, 6'b101010, 1'b1, 1);
    // unused cell inside a variable and at the right end
    run_op("R6 unused", 12'b11_01_11_11_10_01, 12'b10_00_11_11_01_01,
           4'b1000, 1'b0, 4'b1010, 4'b0001, 4'b1001, 6'b100100, 6'b011001, 1'b1, 0);
    // nothing matches: chain reaches the end at once
    run_op("R8 nomatch", 12'b10_01_11_00_01_10, 12'b01_10_00_11_10_01,
           4'b1000, 1'b0, 4'b1110, 4'b0111, 4'b1000, 6'b000000, 6'b111111, 1'b1, 1);
    // start held low: steps leave every cell before
    run_op("R10 nostart", 12'b11_11_11_11_11_11, 12'b11_11_11_11_11_11,
           4'b1000, 1'b0, 4'b1100, 4'b0011, 4'b0000, 6'b000000, 6'b111111, 1'b0, 2);
    // empty results: active and after tables clear the literal
    run_op("R9 emptyops", 12'b01_10_11_00_11_10, 12'b11_10_01_11_11_10,
           4'b1000, 1'b0, 4'b1000, 4'b0000, 4'b0000, 6'b000000, 6'b110011, 1'b1, 0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL [R4] watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule